// File: doc/BRIEF.md
# Multichannel Sync and Start Controller

This block sits in the control plane of a four-channel signal processing device. It watches an asynchronous sync pulse pin and, according to an 8-bit mode word, turns each detected pulse into per-channel beam or hop strobes. It can also arm a hold-off countdown that takes the selected channels out of sleep once the programmed number of clocks has passed.

The mode word and the per-channel sleep flags are written through a small register port. A one-shot setting lets the block react to the first pulse only: that pulse is acted on, and then the whole mode word is wiped, so every later pulse is ignored until software programs the word again.

Top module: `sync_start_ctrl`

## Requirements
- R1: After reset all four sleep flags read 1, and start, beam and hop strobes are 0.
- R2: The sync pin passes through a two-flop synchronizer and is detected on its rising edge. One pulse of any width gives exactly one event. The resulting strobes appear after the third rising clock edge that follows the pin going high.
- R3: With mode bit 6 set, a detected pulse drives beam_strobe to mode bits 3..0 for exactly one clock. Otherwise beam_strobe stays 0.
- R4: With mode bit 5 set, a detected pulse drives hop_strobe to mode bits 3..0 for exactly one clock. Otherwise hop_strobe stays 0.
- R5: With mode bit 4 set, a detected pulse loads the hold-off value N. max(N,1) clocks after the beam/hop strobe edge, the sleep flags selected by mode bits 3..0 at arm time are cleared, and start_strobe is 1 for one clock. Unselected flags keep their value.
- R6: The hold-off count never reaches zero or wraps while running. A value of 0 or 1 wakes on the very next clock.
- R7: With mode bit 7 set, the first detected pulse is acted on and the whole mode word then becomes 0, so later pulses give no strobes and no wake.
- R8: A mode write (wr_sel=0) in the same cycle as the one-shot clear wins, and the written word stays in force.
- R9: A write with wr_sel=1 loads the sleep flags from wr_data bits 3..0. Bit i is channel i. It wins over a wake in the same cycle.
- R10: When mode bit 4 is clear, a sync pulse leaves the sleep flags unchanged and gives no start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_pin | input | 1 | Asynchronous sync pulse input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: mode word, 1: sleep flags |
| wr_data | input | 8 | Write data |
| holdoff_val | input | CNT_W | Hold-off count loaded when a start is armed |
| sleep | output | 4 | Per-channel sleep flags |
| start_strobe | output | 1 | One-clock pulse when channels are woken |
| beam_strobe | output | 4 | Per-channel beam event pulse |
| hop_strobe | output | 4 | Per-channel hop event pulse |

## Verification
A corrupted mode word shows within three clocks of the next sync pulse: the strobes carry the wrong channel mask, or a one-shot word still reacts to a second pulse. A count that is off by one, or that wraps, moves start_strobe and the sleep change away from the edge max(N,1) clocks after the strobes, so cycle-exact sampling catches it at once. A broken synchronizer or edge detector shows as a missing strobe, a repeated strobe, or a strobe on the wrong edge for pulses wider than one clock.

// File: rtl/sync_start_pkg.sv
package sync_start_pkg;
  localparam int NCH = 4;

  typedef struct packed {
    logic           oneshot;  // bit 7
    logic           beam_en;  // bit 6
    logic           hop_en;   // bit 5
    logic           start_en; // bit 4
    logic [NCH-1:0] chan;     // bits 3..0
  } mode_t;

  // channel mask gated by an enable
  function automatic logic [NCH-1:0] gate_mask(input logic en, input logic [NCH-1:0] m);
    return en ? m : '0;
  endfunction

  // hold-off load value: never below one
  function automatic logic [31:0] load_floor(input logic [31:0] v);
    return (v < 32'd1) ? 32'd1 : v;
  endfunction

  // sleep after a wake: selected channels cleared
  function automatic logic [NCH-1:0] wake_apply(input logic [NCH-1:0] s, input logic [NCH-1:0] m);
    return s & ~m;
  endfunction
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] chain_q;

  generate
    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import sync_start_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt,
  input  logic           mode_wr,
  input  logic [7:0]     wr_data,
  output mode_t          mode_q,
  output logic           arm,
  output logic [NCH-1:0] beam_q,
  output logic [NCH-1:0] hop_q
);
  assign arm = evt & mode_q.start_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      beam_q <= '0;
      hop_q  <= '0;
    end else begin
      if (mode_wr)                    mode_q <= mode_t'(wr_data);
      else if (evt && mode_q.oneshot) mode_q <= '0;
      beam_q <= gate_mask(evt & mode_q.beam_en, mode_q.chan);
      hop_q  <= gate_mask(evt & mode_q.hop_en,  mode_q.chan);
    end
  end
endmodule

// File: rtl/holdoff_counter.sv
module holdoff_counter
  import sync_start_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CNT_W-1:0] load_val,
  input  logic [NCH-1:0]   arm_mask,
  output logic             running,
  output logic [CNT_W-1:0] cnt,
  output logic             wake,
  output logic [NCH-1:0]   wake_mask
);
  logic [31:0] ext_val;
  assign ext_val = 32'(load_val);
  // load takes priority over a wake in the same cycle
  assign wake = running & (cnt <= CNT_W'(1)) & ~arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      cnt       <= '0;
      wake_mask <= '0;
    end else if (arm) begin
      running   <= 1'b1;
      cnt       <= CNT_W'(load_floor(ext_val));
      wake_mask <= arm_mask;
    end else if (wake) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sync_start_ctrl.sv
module sync_start_ctrl
  import sync_start_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_pin,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [CNT_W-1:0] holdoff_val,
  output logic [3:0]       sleep,
  output logic             start_strobe,
  output logic [3:0]       beam_strobe,
  output logic [3:0]       hop_strobe
);
  logic             edge_evt;
  logic             arm_evt;
  logic             wake_evt;
  logic             cnt_running;
  logic [CNT_W-1:0] cnt_val;
  logic [NCH-1:0]   wake_sel;
  mode_t            mode_word;
  logic             mode_wr;
  logic             sleep_wr;

  assign mode_wr  = wr_en & ~wr_sel;
  assign sleep_wr = wr_en &  wr_sel;

  sync_edge_det #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sync_pin), .rise(edge_evt)
  );

  mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .evt(edge_evt), .mode_wr(mode_wr),
    .wr_data(wr_data), .mode_q(mode_word), .arm(arm_evt),
    .beam_q(beam_strobe), .hop_q(hop_strobe)
  );

  holdoff_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .arm(arm_evt), .load_val(holdoff_val),
    .arm_mask(mode_word.chan), .running(cnt_running), .cnt(cnt_val),
    .wake(wake_evt), .wake_mask(wake_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleep        <= '1;
      start_strobe <= 1'b0;
    end else begin
      if (sleep_wr)      sleep <= wr_data[NCH-1:0];
      else if (wake_evt) sleep <= wake_apply(sleep, wake_sel);
      start_strobe <= wake_evt;
    end
  end
endmodule

// File: rtl/sync_start_ctrl_chk.sv
module sync_start_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [7:0]       wr_data,
  input logic             edge_evt,
  input logic             wake_evt,
  input logic             running,
  input logic             arm_evt,
  input logic [CNT_W-1:0] cnt,
  input logic [7:0]       mode_bits,
  input logic [3:0]       wake_sel,
  input logic [3:0]       sleep,
  input logic             start_strobe,
  input logic [3:0]       beam_strobe,
  input logic [3:0]       hop_strobe
);
  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) edge_evt |=> !edge_evt); // R2
  AST_BEAM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (beam_strobe != 4'd0) |=> (beam_strobe == 4'd0)); // R3
  AST_BEAM_GATED: assert property (@(posedge clk) disable iff (!rst_n) (beam_strobe != 4'd0) |-> $past(edge_evt && mode_bits[6])); // R3
  AST_HOP_GATED: assert property (@(posedge clk) disable iff (!rst_n) (hop_strobe != 4'd0) |-> $past(edge_evt && mode_bits[5])); // R4
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (wake_evt && !(wr_en && wr_sel)) |=> ((sleep & $past(wake_sel)) == 4'd0)); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) start_strobe |=> !start_strobe); // R5
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) running |-> (cnt != '0)); // R6
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (running && !arm_evt) |=> (cnt <= $past(cnt))); // R6
  AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (edge_evt && mode_bits[7] && !(wr_en && !wr_sel)) |=> (mode_bits == 8'd0)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_sel) |=> (mode_bits == $past(wr_data))); // R8
  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n) !running |=> !start_strobe); // R10
endmodule

bind sync_start_ctrl sync_start_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .edge_evt(edge_evt), .wake_evt(wake_evt), .running(cnt_running),
  .arm_evt(arm_evt), .cnt(cnt_val), .mode_bits(mode_word), .wake_sel(wake_sel),
  .sleep(sleep), .start_strobe(start_strobe), .beam_strobe(beam_strobe),
  .hop_strobe(hop_strobe)
);

// File: tb/sync_start_ctrl_tb.sv
module sync_start_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync_pin = 1'b0;
  logic             wr_en = 1'b0;
  logic             wr_sel = 1'b0;
  logic [7:0]       wr_data = 8'd0;
  logic [CNT_W-1:0] holdoff_val = '0;
  logic [3:0]       sleep;
  logic             start_strobe;
  logic [3:0]       beam_strobe;
  logic [3:0]       hop_strobe;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_mode = 8'd0;
  logic [3:0] exp_sleep = 4'hF;

  always #(CLK_P/2) clk = ~clk;

  sync_start_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .holdoff_val(holdoff_val),
    .sleep(sleep), .start_strobe(start_strobe),
    .beam_strobe(beam_strobe), .hop_strobe(hop_strobe)
  );

  function automatic int wake_delay(input int n);
    return (n < 1) ? 1 : n;
  endfunction

  function automatic logic [3:0] strobe_exp(input logic [7:0] m, input int bitpos, input int k);
    return (k == 3 && m[bitpos]) ? m[3:0] : 4'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel) exp_sleep = d[3:0];
    else     exp_mode  = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one pulse of width w, checked every cycle against exp_mode/exp_sleep
  task automatic pulse_check(input int n, input int w);
    logic [7:0] m;
    logic [3:0] s0;
    int wk;
    m = exp_mode; s0 = exp_sleep;
    wk = 3 + wake_delay(n);
    @(negedge clk);
    sync_pin = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == w) sync_pin = 1'b0;
      check("R3 beam_strobe", 32'(beam_strobe), 32'(strobe_exp(m, 6, k)));
      check("R4 hop_strobe", 32'(hop_strobe), 32'(strobe_exp(m, 5, k)));
      check("R5 start_strobe", 32'(start_strobe), 32'(m[4] && k == wk));
      if (m[4] && k >= wk) check("R5 sleep after wake", 32'(sleep), 32'(s0 & ~m[3:0]));
      else                 check("R10 sleep held", 32'(sleep), 32'(s0));
    end
    if (m[4]) exp_sleep = s0 & ~m[3:0];
    if (m[7]) exp_mode = 8'd0;
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sleep reset", 32'(sleep), 32'hF);
    check("R1 strobes reset", {start_strobe, beam_strobe, hop_strobe}, 32'd0);

    // R2 wide pulse: one event only; R10 no start bit
    reg_write(1'b0, 8'h6A);
    holdoff_val = 16'd3;
    pulse_check(3, 4);

    // R6 zero hold-off wakes next clock
    reg_write(1'b1, 8'h0F);
    reg_write(1'b0, 8'h15);
    holdoff_val = 16'd0;
    pulse_check(0, 1);
    check("R6 zero holdoff sleep", 32'(sleep), 32'hA);

    // R7 one-shot: second pulse ignored
    reg_write(1'b1, 8'h0F);
    reg_write(1'b0, 8'hF3);
    holdoff_val = 16'd2;
    pulse_check(2, 2);
    reg_write(1'b1, 8'h0F);
    pulse_check(2, 2);
    check("R7 one-shot masked sleep", 32'(sleep), 32'hF);

    // R8 write coinciding with one-shot clear wins
    reg_write(1'b0, 8'hC1);
    @(negedge clk);
    sync_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h41;
    @(negedge clk);
    wr_en = 1'b0; sync_pin = 1'b0;
    check("R8 beam on coincident write", 32'(beam_strobe), 32'h1);
    exp_mode = 8'h41;
    idle(4);
    pulse_check(0, 1);

    // R9 sleep write beats wake in same cycle
    reg_write(1'b1, 8'h0F);
    reg_write(1'b0, 8'h13);
    holdoff_val = 16'd2;
    @(negedge clk);
    sync_pin = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1) sync_pin = 1'b0;
      if (k == 4) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h0F; end
      if (k == 5) begin
        wr_en = 1'b0;
        check("R9 sleep write wins", 32'(sleep), 32'hF);
        check("R9 start strobe", 32'(start_strobe), 32'd1);
      end
    end
    exp_sleep = 4'hF;
    idle(6);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int n;
      int w;
      logic [7:0] m;
      logic [3:0] s;
      m = 8'($urandom);
      s = 4'($urandom);
      n = int'($urandom % 7);
      w = 1 + int'($urandom % 4);
      reg_write(1'b1, {4'd0, s});
      reg_write(1'b0, m);
      holdoff_val = CNT_W'(n);
      idle(2);
      pulse_check(n, w);
      if (m[7]) begin
        check("R7 mode cleared", 32'(exp_mode), 32'd0);
        pulse_check(n, w);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule